// File: doc/BRIEF.md
# PHY Address Discovery Scanner

This block is a hardware sequencer that locates a PHY attached to a shared management bus. When it receives a discovery request, it walks the bus addresses from zero upward. At each address it asks the external management serializer to read the first identifier register. The serializer is reached through a request/acknowledge port.

A reply of all ones means the address is empty, and the walk moves on. The first address that answers any other value is taken. At that address the block reads the second identifier register and joins the two halves into a 32-bit identifier. It then looks the identifier up in a parameter table of known parts.

If a whole pass finds nobody, the block waits a programmable number of milliseconds, counted in system clocks, and walks the bus again, up to a fixed number of passes. The result is held on the outputs: the address, the identifier, a known-part flag, and a not-found flag. A successful result is remembered, so later requests complete at once without any bus traffic.

Top module: `phy_scan_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done`, `mreq_valid`, `addr_valid`, `not_found` and `id_known` are 0, and `found_addr` and `phy_id` read 0.
- R2: A scan probes addresses 0, 1, 2 and so on in ascending order, one at a time, with a read of register code 2 (first identifier half). Only register codes 2 and 3 ever appear on `mreq_reg`.
- R3: A register-2 reply of 16'hFFFF marks the address as empty and moves the probe to the next address. Any other reply selects that address, and no higher address is probed in that scan.
- R4: After a selecting reply, one read of register code 3 is issued to the same address. `phy_id` then reads {register-2 reply, register-3 reply}.
- R5: `id_known` is 1 when the identifier equals an entry of the table that lies before the first zero entry. Entries after that zero entry are never matched. The default table is 32'h00012340, 32'h0007C0F1, 32'h0181B8A0, 0, 32'h00225510, 0.
- R6: A responding PHY whose identifier is not matched is still selected: `addr_valid` is 1, `found_addr` holds its address and `id_known` is 0.
- R7: When a pass ends at the top address with no responder, and fewer than MAX_PASSES passes have run, `mreq_valid` stays low for exactly DELAY_MS*CLKS_PER_MS cycles. The next pass then starts again at address 0. No such wait comes before the first pass.
- R8: After MAX_PASSES passes (default 11) with no responder, `not_found` is 1, `addr_valid` is 0 and `found_addr` reads 0. `done` pulses, and exactly MAX_PASSES*32 register-2 reads have been issued.
- R9: Once a PHY has been selected, a later `start` raises `done` in the next cycle without any request, and the outputs stay unchanged.
- R10: `start` while `busy` is 1 has no effect on the scan or its requests.
- R11: `done` is high for one cycle when a discovery ends, and `busy` is 0 in that cycle. A `start` in that same cycle is accepted.
- R12: A request holds `mreq_valid`, `mreq_addr` and `mreq_reg` steady until `mreq_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Discovery request pulse |
| mreq_valid | output | 1 | Register read request to the management serializer |
| mreq_addr | output | ADDR_W | PHY address of the request |
| mreq_reg | output | REG_W | Register code of the request (2 or 3) |
| mreq_ack | input | 1 | One-cycle completion from the serializer |
| mreq_rdata | input | DATA_W | Read data, valid with `mreq_ack` |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle end-of-discovery pulse |
| addr_valid | output | 1 | A PHY has been selected |
| found_addr | output | ADDR_W | Selected address, 0 when not valid |
| phy_id | output | 2*DATA_W | Joined identifier, 0 when not valid |
| id_known | output | 1 | Identifier is in the table |
| not_found | output | 1 | All passes ended with no responder |

## Verification
A finished discovery and a new request can meet in one cycle: the cycle in which `done` pulses is also a cycle in which `start` is sampled. The bench raises `start` exactly in the cycle it sees `done`. With a remembered PHY it expects a second `done` in the following cycle, with no request. A second collision arises when a request is raised while a scan is running. That `start` is dropped, and the bench checks that the total count of register-2 reads and the timing of every request still match its cycle model.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;

   typedef enum logic [2:0] {
      SC_IDLE  = 3'd0,
      SC_RD1   = 3'd1,
      SC_RD2   = 3'd2,
      SC_MATCH = 3'd3,
      SC_WAIT  = 3'd4
   } scan_state_t;

endpackage

// File: rtl/phy_pass_timer.sv
module phy_pass_timer #(
   parameter int TOTAL = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expire
);
   localparam int CW = $clog2(TOTAL + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= CW'(TOTAL);
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   // Fires in the last waiting cycle, so the wait lasts TOTAL cycles.
   assign expire = (cnt == CW'(1));
endmodule

// File: rtl/phy_id_match.sv
module phy_id_match #(
   parameter int ID_W        = 32,
   parameter int TABLE_DEPTH = 6,
   parameter logic [TABLE_DEPTH-1:0][ID_W-1:0] TABLE = '0
) (
   input  logic [ID_W-1:0] id,
   output logic            hit
);
   logic [TABLE_DEPTH-1:0] live;
   logic [TABLE_DEPTH-1:0] eq;

   // An entry is live while no zero entry precedes or equals it.
   for (genvar i = 0; i < TABLE_DEPTH; i++) begin : g_entry
      if (i == 0) begin : g_first
         assign live[i] = (TABLE[i] != '0);
      end else begin : g_rest
         assign live[i] = live[i-1] && (TABLE[i] != '0);
      end
      assign eq[i] = live[i] && (TABLE[i] == id);
   end

   assign hit = |eq;
endmodule

// File: rtl/phy_scan_fsm.sv
module phy_scan_fsm
   import phy_scan_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int REG_W      = 5,
   parameter int DATA_W     = 16,
   parameter int MAX_PASSES = 11,
   parameter int ID1_REG    = 2,
   parameter int ID2_REG    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  ack,
   input  logic [DATA_W-1:0]     rdata,
   input  logic                  hit,
   input  logic                  expire,
   output logic                  timer_load,
   output logic                  req_valid,
   output logic [ADDR_W-1:0]     req_addr,
   output logic [REG_W-1:0]      req_reg,
   output logic                  busy,
   output logic                  done,
   output logic                  sel_valid,
   output logic [ADDR_W-1:0]     sel_addr,
   output logic [2*DATA_W-1:0]   id_raw,
   output logic                  known,
   output logic                  missing
);
   localparam int          PW       = $clog2(MAX_PASSES + 1);
   localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
   localparam logic [DATA_W-1:0] ABSENT    = {DATA_W{1'b1}};

   scan_state_t       state;
   logic [ADDR_W-1:0] addr_q;
   logic [PW-1:0]     pass_q;
   logic              have_q;

   wire empty_reply = (rdata == ABSENT);
   wire last_addr   = (addr_q == LAST_ADDR);
   wire last_pass   = (pass_q == PW'(MAX_PASSES));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= SC_IDLE;
         addr_q    <= '0;
         pass_q    <= '0;
         have_q    <= 1'b0;
         done      <= 1'b0;
         sel_valid <= 1'b0;
         id_raw    <= '0;
         known     <= 1'b0;
         missing   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            SC_IDLE: begin
               if (start) begin
                  if (have_q) begin
                     done <= 1'b1;
                  end else begin
                     addr_q    <= '0;
                     pass_q    <= PW'(1);
                     sel_valid <= 1'b0;
                     missing   <= 1'b0;
                     known     <= 1'b0;
                     id_raw    <= '0;
                     state     <= SC_RD1;
                  end
               end
            end
            SC_RD1: begin
               if (ack) begin
                  if (!empty_reply) begin
                     id_raw[2*DATA_W-1:DATA_W] <= rdata;
                     state <= SC_RD2;
                  end else if (!last_addr) begin
                     addr_q <= addr_q + 1'b1;
                  end else if (last_pass) begin
                     missing <= 1'b1;
                     done    <= 1'b1;
                     state   <= SC_IDLE;
                  end else begin
                     pass_q <= pass_q + 1'b1;
                     state  <= SC_WAIT;
                  end
               end
            end
            SC_RD2: begin
               if (ack) begin
                  id_raw[DATA_W-1:0] <= rdata;
                  state <= SC_MATCH;
               end
            end
            SC_MATCH: begin
               known     <= hit;
               sel_valid <= 1'b1;
               have_q    <= 1'b1;
               done      <= 1'b1;
               state     <= SC_IDLE;
            end
            SC_WAIT: begin
               if (expire) begin
                  addr_q <= '0;
                  state  <= SC_RD1;
               end
            end
            default: state <= SC_IDLE;
         endcase
      end
   end

   assign timer_load = (state == SC_RD1) && ack && empty_reply && last_addr && !last_pass;
   assign req_valid  = (state == SC_RD1) || (state == SC_RD2);
   assign req_addr   = addr_q;
   assign req_reg    = (state == SC_RD2) ? REG_W'(ID2_REG) : REG_W'(ID1_REG);
   assign busy       = (state != SC_IDLE);
   assign sel_addr   = addr_q;
endmodule

// File: rtl/phy_scan_ctrl.sv
module phy_scan_ctrl #(
   parameter int ADDR_W      = 5,
   parameter int REG_W       = 5,
   parameter int DATA_W      = 16,
   parameter int MAX_PASSES  = 11,
   parameter int DELAY_MS    = 10,
   parameter int CLKS_PER_MS = 100000,
   parameter int ID1_REG     = 2,
   parameter int ID2_REG     = 3,
   parameter int TABLE_DEPTH = 6,
   parameter logic [TABLE_DEPTH-1:0][2*DATA_W-1:0] KNOWN_IDS = {
      32'h0000_0000, 32'h0022_5510, 32'h0000_0000,
      32'h0181_B8A0, 32'h0007_C0F1, 32'h0001_2340}
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   output logic                mreq_valid,
   output logic [ADDR_W-1:0]   mreq_addr,
   output logic [REG_W-1:0]    mreq_reg,
   input  logic                mreq_ack,
   input  logic [DATA_W-1:0]   mreq_rdata,
   output logic                busy,
   output logic                done,
   output logic                addr_valid,
   output logic [ADDR_W-1:0]   found_addr,
   output logic [2*DATA_W-1:0] phy_id,
   output logic                id_known,
   output logic                not_found
);
   localparam int ID_W  = 2 * DATA_W;
   localparam int TOTAL = DELAY_MS * CLKS_PER_MS;

   if (ADDR_W < 1 || REG_W < 2 || DATA_W < 1) begin : g_bad_width
      $error("phy_scan_ctrl: address, register or data width out of range");
   end
   if (MAX_PASSES < 1 || TABLE_DEPTH < 1) begin : g_bad_count
      $error("phy_scan_ctrl: pass count and table depth must be at least 1");
   end
   if (TOTAL < 1) begin : g_bad_delay
      $error("phy_scan_ctrl: retry delay must be at least one clock");
   end
   if (ID1_REG == ID2_REG || ID1_REG >= 2**REG_W || ID2_REG >= 2**REG_W) begin : g_bad_reg
      $error("phy_scan_ctrl: identifier register codes invalid");
   end

   logic            timer_load;
   logic            expire;
   logic            hit;
   logic [ID_W-1:0] id_raw;
   logic [ADDR_W-1:0] sel_addr;

   phy_scan_fsm #(
      .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W),
      .MAX_PASSES(MAX_PASSES), .ID1_REG(ID1_REG), .ID2_REG(ID2_REG)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start),
      .ack(mreq_ack), .rdata(mreq_rdata), .hit(hit), .expire(expire),
      .timer_load(timer_load),
      .req_valid(mreq_valid), .req_addr(mreq_addr), .req_reg(mreq_reg),
      .busy(busy), .done(done), .sel_valid(addr_valid),
      .sel_addr(sel_addr), .id_raw(id_raw),
      .known(id_known), .missing(not_found)
   );

   phy_pass_timer #(.TOTAL(TOTAL)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(timer_load), .expire(expire)
   );

   phy_id_match #(
      .ID_W(ID_W), .TABLE_DEPTH(TABLE_DEPTH), .TABLE(KNOWN_IDS)
   ) u_match (
      .id(id_raw), .hit(hit)
   );

   assign found_addr = addr_valid ? sel_addr : '0;
   assign phy_id     = addr_valid ? id_raw : '0;
endmodule

// File: rtl/phy_scan_chk.sv
module phy_scan_chk #(
   parameter int ADDR_W  = 5,
   parameter int REG_W   = 5,
   parameter int DATA_W  = 16,
   parameter int ID1_REG = 2,
   parameter int ID2_REG = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                mreq_valid,
   input logic [ADDR_W-1:0]   mreq_addr,
   input logic [REG_W-1:0]    mreq_reg,
   input logic                mreq_ack,
   input logic [DATA_W-1:0]   mreq_rdata,
   input logic                busy,
   input logic                done,
   input logic                addr_valid,
   input logic [ADDR_W-1:0]   found_addr,
   input logic [2*DATA_W-1:0] phy_id,
   input logic                id_known,
   input logic                not_found
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_valid && !mreq_ack |=> mreq_valid && $stable(mreq_addr) && $stable(mreq_reg)); // R12
   AST_REG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_valid |-> (mreq_reg == REG_W'(ID1_REG) || mreq_reg == REG_W'(ID2_REG))); // R2
   AST_PASS_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mreq_valid) |-> mreq_addr == '0); // R7
   AST_ID2_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_valid && mreq_reg == REG_W'(ID2_REG) && $past(mreq_reg) == REG_W'(ID1_REG)
      |-> $stable(mreq_addr)); // R4
   AST_NO_BOTH_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
      !(addr_valid && not_found)); // R8
   AST_KNOWN_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      id_known |-> addr_valid); // R6
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R11
endmodule

bind phy_scan_ctrl phy_scan_chk u_chk (.*);

// File: tb/tb_phy_scan_ctrl.sv
module tb_phy_scan_ctrl;
   localparam int CPM   = 20;
   localparam int DLY   = 10;
   localparam int TOTAL = CPM * DLY;
   localparam int NPASS = 11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        mreq_valid;
   logic [4:0]  mreq_addr;
   logic [4:0]  mreq_reg;
   logic        mreq_ack = 1'b0;
   logic [15:0] mreq_rdata = 16'h0;
   logic        busy, done, addr_valid, id_known, not_found;
   logic [4:0]  found_addr;
   logic [31:0] phy_id;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   phy_scan_ctrl #(.CLKS_PER_MS(CPM), .DELAY_MS(DLY)) dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .mreq_valid(mreq_valid), .mreq_addr(mreq_addr), .mreq_reg(mreq_reg),
      .mreq_ack(mreq_ack), .mreq_rdata(mreq_rdata),
      .busy(busy), .done(done), .addr_valid(addr_valid),
      .found_addr(found_addr), .phy_id(phy_id),
      .id_known(id_known), .not_found(not_found)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Known-part list, written from the requirement.
   logic [31:0] tbl [6] = '{32'h00012340, 32'h0007C0F1, 32'h0181B8A0, 32'h0, 32'h00225510, 32'h0};

   function automatic bit in_table(input logic [31:0] v);
      for (int i = 0; i < 6; i++) begin
         if (tbl[i] == 32'h0) return 1'b0;
         if (tbl[i] == v) return 1'b1;
      end
      return 1'b0;
   endfunction

   // Responder: a PHY at one address, answering after a latency.
   bit          phy_on = 1'b0;
   logic [4:0]  phy_at = 5'd0;
   logic [31:0] phy_val = 32'h0;
   int          wake_n = 0;
   int          lat = 1;
   int          id1_cnt = 0;
   int          hold = 0;

   initial begin
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            mreq_ack = 1'b0;
            hold = 0;
         end else if (mreq_ack) begin
            mreq_ack = 1'b0;
         end else if (mreq_valid) begin
            if (hold >= lat) begin
               hold = 0;
               mreq_ack = 1'b1;
               if (phy_on && mreq_addr == phy_at && id1_cnt >= wake_n)
                  mreq_rdata = (mreq_reg == 5'd2) ? phy_val[31:16] : phy_val[15:0];
               else
                  mreq_rdata = 16'hFFFF;
               if (mreq_reg == 5'd2) id1_cnt++;
            end else begin
               hold++;
            end
         end
      end
   end

   // Behavioural cycle model: phase 0 idle, 1 first read, 2 second read, 3 lookup, 4 wait.
   int          ph = 0;
   int          m_addr = 0;
   int          m_pass = 0;
   int          m_wait = 0;
   bit          m_have = 0;
   bit          m_done = 0, m_valid = 0, m_known = 0, m_nf = 0;
   logic [31:0] m_id = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; m_addr = 0; m_pass = 0; m_wait = 0; m_have = 0;
         m_done = 0; m_valid = 0; m_known = 0; m_nf = 0; m_id = 0;
      end else begin
         m_done = 0;
         case (ph)
            0: if (start) begin
                  if (m_have) m_done = 1;
                  else begin
                     m_addr = 0; m_pass = 1; m_valid = 0; m_known = 0; m_nf = 0; m_id = 0; ph = 1;
                  end
               end
            1: if (mreq_ack) begin
                  if (mreq_rdata != 16'hFFFF) begin
                     m_id[31:16] = mreq_rdata; ph = 2;
                  end else if (m_addr < 31) m_addr++;
                  else if (m_pass == NPASS) begin
                     m_nf = 1; m_done = 1; ph = 0;
                  end else begin
                     m_pass++; m_wait = TOTAL; ph = 4;
                  end
               end
            2: if (mreq_ack) begin
                  m_id[15:0] = mreq_rdata; ph = 3;
               end
            3: begin
                  m_known = in_table(m_id); m_valid = 1; m_have = 1; m_done = 1; ph = 0;
               end
            default: begin
                  m_wait--;
                  if (m_wait == 0) begin m_addr = 0; ph = 1; end
               end
         endcase
      end
   end

   // Compare every cycle, away from the active edge.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            chk(mreq_valid == (ph == 1 || ph == 2), "R12 mreq_valid", mreq_valid, (ph == 1 || ph == 2));
            if (ph == 1 || ph == 2) begin
               chk(mreq_addr == 5'(m_addr), "R2 mreq_addr", mreq_addr, m_addr);
               chk(mreq_reg == ((ph == 2) ? 5'd3 : 5'd2), "R2 mreq_reg", mreq_reg, (ph == 2) ? 3 : 2);
            end
            chk(busy == (ph != 0), "R10 busy", busy, ph != 0);
            chk(done == m_done, "R11 done", done, m_done);
            chk(addr_valid == m_valid, "R6 addr_valid", addr_valid, m_valid);
            chk(found_addr == (m_valid ? 5'(m_addr) : 5'd0), "R3 found_addr", found_addr, m_valid ? m_addr : 0);
            chk(phy_id == (m_valid ? m_id : 32'h0), "R4 phy_id", phy_id, m_valid ? m_id : 0);
            chk(id_known == m_known, "R5 id_known", id_known, m_known);
            chk(not_found == m_nf, "R8 not_found", not_found, m_nf);
         end
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=timeout expected=done");
      summary();
      $finish;
   end

   task automatic do_reset(input bit on, input logic [4:0] at, input logic [31:0] v, input int wk, input int l);
      @(negedge clk);
      rst_n = 1'b0; start = 1'b0;
      phy_on = on; phy_at = at; phy_val = v; wake_n = wk; lat = l; id1_cnt = 0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !mreq_valid && !addr_valid && !not_found && !id_known
          && found_addr == 0 && phy_id == 0, "R1 reset state", {busy, done, mreq_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   int gap;
   int dones;

   initial begin
      // R2 R3 R4 R5: known part at address 5.
      do_reset(1, 5'd5, 32'h0007C0F1, 0, 2);
      pulse_start();
      wait_done();
      chk(addr_valid && found_addr == 5 && phy_id == 32'h0007C0F1, "R4 known part id", phy_id, 32'h0007C0F1);
      chk(id_known == 1, "R5 known flag", id_known, 1);
      chk(id1_cnt == 6, "R3 probes up to responder", id1_cnt, 6);
      // R11: start in the done cycle, cached PHY answers next cycle.
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1 && !mreq_valid, "R11 start in done cycle", done, 1);
      // R9: later request with a cached result.
      repeat (4) @(negedge clk);
      pulse_start();
      chk(done == 1 && !busy && found_addr == 5 && id_known, "R9 cached reply", done, 1);
      chk(id1_cnt == 6, "R9 no rescan", id1_cnt, 6);

      // R6: unknown part at address 0, zero latency.
      do_reset(1, 5'd0, 32'h1234ABCD, 0, 0);
      pulse_start();
      wait_done();
      chk(addr_valid && found_addr == 0 && !id_known, "R6 unknown selected", id_known, 0);
      chk(phy_id == 32'h1234ABCD, "R4 unknown id", phy_id, 32'h1234ABCD);

      // R5: entry past the zero terminator never matches; top address.
      do_reset(1, 5'd31, 32'h00225510, 0, 1);
      pulse_start();
      wait_done();
      chk(addr_valid && found_addr == 31, "R3 top address", found_addr, 31);
      chk(id_known == 0, "R5 after terminator", id_known, 1'b0);

      // R7: PHY wakes during the third pass; count quiet busy cycles.
      do_reset(1, 5'd7, 32'h0181B8A0, 64, 1);
      gap = 0;
      pulse_start();
      while (!done) begin
         if (busy && !mreq_valid) gap++;
         @(negedge clk);
      end
      chk(gap == 2 * TOTAL + 1, "R7 retry wait length", gap, 2 * TOTAL + 1);
      chk(found_addr == 7 && id_known, "R7 found on third pass", found_addr, 7);

      // R8 R10: nobody present; extra start while busy is ignored.
      do_reset(0, 5'd0, 32'h0, 0, 1);
      pulse_start();
      repeat (50) @(negedge clk);
      pulse_start();
      dones = 0;
      while (!done) @(negedge clk);
      dones++;
      chk(not_found && !addr_valid && found_addr == 0, "R8 not found", not_found, 1);
      chk(id1_cnt == NPASS * 32, "R10 probe count", id1_cnt, NPASS * 32);
      repeat (5) begin
         @(negedge clk);
         if (done) dones++;
      end
      chk(dones == 1 && !busy, "R10 single completion", dones, 1);

      summary();
      $finish;
   end
endmodule